// File: doc/BRIEF.md
# Double-Edge Strobed Burst Link

This block moves bursts of 16-bit words across a parallel link in which the sending side drives both the data lines and a strobe. A word is carried on every strobe transition, rising and falling alike, so the word rate is twice the strobe frequency. The strobe half-period is a programmable number of system clocks. The sender changes the data on one clock and toggles the strobe on a later clock, so the data is already stable when the edge arrives.

The receiving side samples the link in the system clock domain and turns each strobe transition into one word in a small receive FIFO. When the FIFO fills, it raises a pause request that freezes the strobe. Both sides seed a CRC-16 at the start of every burst and fold in each word. On termination the sender places its CRC on the data lines and then drops the burst-active line. The receiver compares the value it receives with its own CRC and pulses a match or a mismatch output.

The top module holds both ends. The link outputs of the sender and the link inputs of the receiver are separate ports, so the integrating level joins them, the same way a cable would.

Top module: `dsl_link`

## Requirements
- R1: Every strobe transition seen while the burst-active line is high, rising or falling, delivers exactly one word to the receive FIFO, and words leave the FIFO in the order they were sent.
- R2: While words are available and the link is not paused, consecutive strobe transitions are `half_div_i` clocks apart. A value below 2 acts as 2.
- R3: The receive FIFO holds 8 words. `rx_valid_o` is high while it holds any word, and the word at its head stays unchanged until it is read with `rx_ready_i`. `pause_o` is high while 6 or more words are held, and no word is ever dropped.
- R4: While `pause_o` is high the sender accepts no word and the strobe does not toggle. After pause clears, the strobe continues with the opposite polarity, and every word arrives once.
- R5: Each side's CRC uses the polynomial x^16+x^12+x^5+1 (0x1021). It processes each word from bit 15 down to bit 0, left-shifting with feedback `crc[15]^bit`, and is seeded with 0x4ABA at the start of every burst.
- R6: On termination the sender drives its CRC onto `link_data_o` for at least one clock while `link_act_o` is high. It then lowers `link_act_o` and returns the strobe to 0 on the same clock. That final strobe change is not counted as a word, so bursts of odd or even length deliver exactly the words sent, and a burst of zero words is legal.
- R7: After the burst-active line falls, the receiver pulses `crc_ok_o` for one clock when the received CRC equals its own, or `crc_error_o` for one clock when they differ. The two are never high together.
- R8: Transfer and CRC check remain correct at any slower half-period setting.
- R9: After reset `link_act_o`, `link_strobe_o`, `src_ready_o`, `rx_valid_o`, `pause_o`, `crc_ok_o` and `crc_error_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | 8 | Strobe half-period in clocks (minimum 2) |
| burst_start_i | input | 1 | Pulse: open a burst (used when idle) |
| burst_end_i | input | 1 | Pulse: terminate the burst after the word in flight |
| src_valid_i | input | 1 | Sender word available |
| src_data_i | input | 16 | Sender word |
| src_ready_o | output | 1 | Sender takes the word on this clock |
| link_act_o | output | 1 | Burst-active line driven by the sender |
| link_strobe_o | output | 1 | Strobe driven by the sender |
| link_data_o | output | 16 | Data lines driven by the sender |
| link_act_i | input | 1 | Burst-active line seen by the receiver |
| link_strobe_i | input | 1 | Strobe seen by the receiver |
| link_data_i | input | 16 | Data lines seen by the receiver |
| rx_valid_o | output | 1 | Receive FIFO holds a word |
| rx_data_o | output | 16 | Word at the FIFO head |
| rx_ready_i | input | 1 | Consumer reads the head word |
| pause_o | output | 1 | Receiver pause request |
| crc_ok_o | output | 1 | One-clock pulse: CRCs matched |
| crc_error_o | output | 1 | One-clock pulse: CRCs differed |

## Verification
The bench uses the default build: an 8-entry FIFO with a pause level of 6 and an 8-bit divider. The link is looped back through an XOR mask on the data lines. Because of the mask, a corrupted word produces a genuine CRC mismatch, while the sender still reports its true CRC on the lines. Runtime divider settings of 0, 2, 3 and 7 cover the clamped minimum, the fastest rate with a word in flight during pause, and slow transfers. A 12-word burst with the consumer stalled drives the FIFO into pause and back out.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;

  typedef enum logic [1:0] {TX_IDLE, TX_RUN, TX_EDGE, TX_TERM} tx_state_e;

  function automatic logic [15:0] crc16_word(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/dsl_crc16.sv
module dsl_crc16
  import dsl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [15:0]       crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_SEED;
    else if (seed_i) crc_o <= CRC_SEED;
    else if (upd_i)  crc_o <= crc16_word(crc_o, data_i);
  end
endmodule

// File: rtl/dsl_fifo.sv
module dsl_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic push_ok, pop_ok;

  assign push_ok = push_i && (level_o != FULL);
  assign pop_ok  = pop_i && (level_o != '0);
  assign rdata_o = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_o <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level_o <= level_o + 1'b1;
        2'b01:   level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end
endmodule

// File: rtl/dsl_tx.sv
module dsl_tx
  import dsl_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              pause_i,
  input  logic              src_valid_i,
  input  logic [WORD_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              act_o,
  output logic              strobe_o,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  tx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q, div_eff;
  logic              end_req_q, load, seed;
  logic [15:0]       host_crc;

  assign div_eff     = (half_div_i < MIN_DIV) ? MIN_DIV : half_div_i;
  assign src_ready_o = (state_q == TX_RUN) && (cnt_q == '0) && !end_req_q && !pause_i;
  assign load        = src_ready_o && src_valid_i;
  assign seed        = (state_q == TX_IDLE) && start_i;

  dsl_crc16 u_host_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (seed),
    .upd_i  (load),
    .data_i (src_data_i),
    .crc_o  (host_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      cnt_q     <= '0;
      end_req_q <= 1'b0;
      act_o     <= 1'b0;
      strobe_o  <= 1'b0;
      data_o    <= '0;
    end else begin
      if (end_i && (state_q == TX_RUN || state_q == TX_EDGE)) end_req_q <= 1'b1;
      case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            state_q   <= TX_RUN;
            act_o     <= 1'b1;
            cnt_q     <= '0;
            end_req_q <= 1'b0;
          end
        end
        TX_RUN: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (end_req_q) begin
            data_o  <= host_crc;
            state_q <= TX_TERM;
          end else if (load) begin
            data_o  <= src_data_i;
            state_q <= TX_EDGE;
          end
        end
        TX_EDGE: begin
          strobe_o <= ~strobe_o;
          cnt_q    <= div_eff - MIN_DIV;
          state_q  <= TX_RUN;
        end
        TX_TERM: begin
          act_o    <= 1'b0;
          strobe_o <= 1'b0;
          state_q  <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsl_rx.sv
module dsl_rx
  import dsl_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PAUSE_LVL = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_i,
  input  logic                       strobe_i,
  input  logic [WORD_W-1:0]          data_i,
  input  logic                       rd_ready_i,
  output logic                       rd_valid_o,
  output logic [WORD_W-1:0]          rd_data_o,
  output logic                       pause_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       ok_o,
  output logic                       err_o
);
  localparam int unsigned LW = $clog2(DEPTH+1);

  logic              act_q, act_qq, strb_q, strb_qq;
  logic [WORD_W-1:0] data_q;
  logic              edge_hit, act_rise, act_fall;
  logic [15:0]       dev_crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      act_qq  <= 1'b0;
      strb_q  <= 1'b0;
      strb_qq <= 1'b0;
      data_q  <= '0;
    end else begin
      act_q   <= act_i;
      act_qq  <= act_q;
      strb_q  <= strobe_i;
      strb_qq <= strb_q;
      data_q  <= data_i;
    end
  end

  // a strobe change that coincides with the active line dropping is not a word
  assign edge_hit = act_q && act_qq && (strb_q != strb_qq);
  assign act_rise = act_q && !act_qq;
  assign act_fall = !act_q && act_qq;

  dsl_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (edge_hit),
    .wdata_i (data_q),
    .pop_i   (rd_ready_i),
    .rdata_o (rd_data_o),
    .level_o (level_o)
  );

  assign rd_valid_o = (level_o != '0);
  assign pause_o    = (level_o >= LW'(PAUSE_LVL));

  dsl_crc16 u_dev_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (act_rise),
    .upd_i  (edge_hit),
    .data_i (data_q),
    .crc_o  (dev_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      ok_o  <= act_fall && (data_q == dev_crc);
      err_o <= act_fall && (data_q != dev_crc);
    end
  end
endmodule

// File: rtl/dsl_link.sv
module dsl_link
  import dsl_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned PAUSE_LVL  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              burst_start_i,
  input  logic              burst_end_i,
  input  logic              src_valid_i,
  input  logic [15:0]       src_data_i,
  output logic              src_ready_o,
  output logic              link_act_o,
  output logic              link_strobe_o,
  output logic [15:0]       link_data_o,
  input  logic              link_act_i,
  input  logic              link_strobe_i,
  input  logic [15:0]       link_data_i,
  output logic              rx_valid_o,
  output logic [15:0]       rx_data_o,
  input  logic              rx_ready_i,
  output logic              pause_o,
  output logic              crc_ok_o,
  output logic              crc_error_o
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH+1);

  logic [LVL_W-1:0] rx_level;

  dsl_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_div_i  (half_div_i),
    .start_i     (burst_start_i),
    .end_i       (burst_end_i),
    .pause_i     (pause_o),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_ready_o (src_ready_o),
    .act_o       (link_act_o),
    .strobe_o    (link_strobe_o),
    .data_o      (link_data_o)
  );

  dsl_rx #(.DEPTH(FIFO_DEPTH), .PAUSE_LVL(PAUSE_LVL)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (link_act_i),
    .strobe_i   (link_strobe_i),
    .data_i     (link_data_i),
    .rd_ready_i (rx_ready_i),
    .rd_valid_o (rx_valid_o),
    .rd_data_o  (rx_data_o),
    .pause_o    (pause_o),
    .level_o    (rx_level),
    .ok_o       (crc_ok_o),
    .err_o      (crc_error_o)
  );
endmodule

// File: rtl/dsl_link_chk.sv
module dsl_link_chk #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pause_i,
  input logic             link_act_i,
  input logic             link_strobe_i,
  input logic             crc_ok_i,
  input logic             crc_error_i,
  input logic             rx_valid_i,
  input logic             rx_ready_i,
  input logic [15:0]      rx_data_i,
  input logic [LVL_W-1:0] level_i
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(DEPTH));

  assert_head_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ready_i) |=> (rx_valid_i && $stable(rx_data_i)));

  assert_pause_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pause_i, 2) && $past(pause_i) && pause_i && link_act_i) |-> $stable(link_strobe_i));

  assert_term_strobe_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_act_i) |-> !link_strobe_i);

  assert_verdict_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crc_ok_i && crc_error_i));

  assert_ok_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ok_i |=> !crc_ok_i);

  assert_err_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_error_i |=> !crc_error_i);
endmodule

bind dsl_link dsl_link_chk #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pause_i       (pause_o),
  .link_act_i    (link_act_o),
  .link_strobe_i (link_strobe_o),
  .crc_ok_i      (crc_ok_o),
  .crc_error_i   (crc_error_o),
  .rx_valid_i    (rx_valid_o),
  .rx_ready_i    (rx_ready_i),
  .rx_data_i     (rx_data_o),
  .level_i       (rx_level)
);

// File: tb/dsl_link_tb.sv
module dsl_link_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic        burst_start = 1'b0, burst_end = 1'b0;
  logic        src_valid = 1'b0;
  logic [15:0] src_data = '0;
  logic        src_ready;
  logic        l_act, l_strb;
  logic [15:0] l_data, flip = '0;
  logic        rx_valid, rx_ready, pause, ok, err;
  logic [15:0] rx_data;
  logic        drain_en = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [15:0] words [64];
  logic [15:0] got [64];
  int ngot = 0, nedges = 0, last_tog = 0, last_gap = 0, nterm = 0;
  logic [15:0] term_crc = '0;
  logic term_strb = 1'b0, prev_act = 1'b0, prev_strb = 1'b0;
  int ok_hi, err_hi;

  assign rx_ready = drain_en;

  always #5 clk = ~clk;

  dsl_link u_dut (
    .clk_i (clk), .rst_ni (rst_n), .half_div_i (half_div),
    .burst_start_i (burst_start), .burst_end_i (burst_end),
    .src_valid_i (src_valid), .src_data_i (src_data), .src_ready_o (src_ready),
    .link_act_o (l_act), .link_strobe_o (l_strb), .link_data_o (l_data),
    .link_act_i (l_act), .link_strobe_i (l_strb), .link_data_i (l_data ^ flip),
    .rx_valid_o (rx_valid), .rx_data_o (rx_data), .rx_ready_i (rx_ready),
    .pause_o (pause), .crc_ok_o (ok), .crc_error_o (err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // receive collector and link monitor, sampled away from the edge
  always @(negedge clk) begin
    #1;
    if (rx_ready && rx_valid && ngot < 64) begin
      got[ngot] = rx_data;
      ngot = ngot + 1;
    end
    if (l_act && prev_act && (l_strb != prev_strb)) begin
      nedges   = nedges + 1;
      last_gap = cyc - last_tog;
      last_tog = cyc;
    end
    if (prev_act && !l_act) begin
      term_crc  = l_data;
      term_strb = l_strb;
      nterm     = nterm + 1;
    end
    prev_act  = l_act;
    prev_strb = l_strb;
  end

  task automatic check_eq(input string req, input string what, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h4ABA;
    for (int w = 0; w < n; w++) begin
      for (int b = 0; b < 16; b++) begin
        logic top;
        top = c[15] ^ words[w][15-b];
        c = {c[14:0], 1'b0} ^ (top ? 16'h1021 : 16'h0000);
      end
    end
    return c;
  endfunction

  task automatic make_words(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) words[i] = base + 16'(i * 16'h3B5D);
  endtask

  task automatic send_word(input logic [15:0] w);
    src_valid = 1'b1;
    src_data  = w;
    #1;
    while (!src_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic open_burst(input logic [7:0] div);
    @(negedge clk);
    half_div = div;
    ngot = 0;
    nedges = 0;
    burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 400 && ngot < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic close_burst();
    ok_hi = 0;
    err_hi = 0;
    @(negedge clk);
    flip = '0;
    burst_end = 1'b1;
    @(negedge clk);
    burst_end = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #1;
      if (ok) ok_hi++;
      if (err) err_hi++;
    end
  endtask

  task automatic check_words(input string req, input int n, input logic [15:0] mask);
    check_eq(req, "word count", ngot, n);
    check_eq(req, "strobe edges", nedges, n);
    for (int i = 0; i < n && i < ngot; i++)
      if (got[i] != (words[i] ^ mask)) check_eq(req, "word order/value", got[i], words[i] ^ mask);
  endtask

  task automatic run_clean(input string req, input int n, input logic [7:0] div, input int exp_gap);
    make_words(n, 16'(n * 16'h0101 + div));
    open_burst(div);
    for (int i = 0; i < n; i++) send_word(words[i]);
    src_valid = 1'b0;
    wait_words(n);
    if (exp_gap > 0) check_eq("R2", "strobe half-period", last_gap, exp_gap);
    close_burst();
    check_words(req, n, 16'h0);
    check_eq("R5", "host CRC on lines", term_crc, ref_crc(n));
    check_eq("R6", "strobe level at termination", term_strb, 0);
    check_eq("R7", "crc_ok pulse width", ok_hi, 1);
    check_eq("R7", "crc_error quiet", err_hi, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    check_eq("R9", "reset outputs",
             {l_act, l_strb, src_ready, rx_valid, pause, ok, err}, 0);
  endtask

  task automatic t_pause();
    int ne0;
    logic s0;
    bit seen;
    make_words(12, 16'hC0DE);
    drain_en = 1'b0;
    open_burst(8'd2);
    fork
      begin
        for (int i = 0; i < 12; i++) send_word(words[i]);
        src_valid = 1'b0;
      end
      begin
        seen = 1'b0;
        for (int i = 0; i < 300 && !seen; i++) begin
          @(negedge clk);
          #1;
          seen = pause;
        end
        check_eq("R3", "pause raised with stalled consumer", seen, 1);
        check_eq("R3", "head word available", rx_valid, 1);
        repeat (4) @(negedge clk);
        #1;
        ne0 = nedges;
        s0 = l_strb;
        repeat (30) @(negedge clk);
        #1;
        check_eq("R4", "no strobe edge while paused", nedges, ne0);
        check_eq("R4", "strobe level frozen", l_strb, s0);
        check_eq("R4", "sender stalled", src_ready, 0);
        drain_en = 1'b1;
      end
    join
    wait_words(12);
    close_burst();
    check_words("R4", 12, 16'h0);
    check_eq("R3", "fifo empty after drain", rx_valid, 0);
    check_eq("R7", "crc_ok after pause", ok_hi, 1);
  endtask

  task automatic t_corrupt();
    make_words(6, 16'h1234);
    open_burst(8'd3);
    flip = 16'h0100;
    for (int i = 0; i < 6; i++) send_word(words[i]);
    src_valid = 1'b0;
    wait_words(6);
    close_burst();
    check_words("R1", 6, 16'h0100);
    check_eq("R5", "host CRC over true words", term_crc, ref_crc(6));
    check_eq("R7", "crc_error pulse width", err_hi, 1);
    check_eq("R7", "crc_ok quiet on mismatch", ok_hi, 0);
  endtask

  task automatic t_empty();
    open_burst(8'd2);
    close_burst();
    check_eq("R6", "zero-word burst edges", nedges, 0);
    check_eq("R5", "seed value on lines", term_crc, 16'h4ABA);
    check_eq("R7", "crc_ok on empty burst", ok_hi, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_clean("R1", 4, 8'd2, 2);   // even count, fastest rate
        run_clean("R6", 5, 8'd3, 3);   // odd count ends with strobe high
        run_clean("R8", 3, 8'd7, 7);   // reduced speed
        run_clean("R2", 4, 8'd0, 2);   // divider below minimum
        t_pause();
        t_corrupt();
        run_clean("R5", 7, 8'd2, 2);   // fresh seed after a failed burst
        t_empty();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule